// File: doc/BRIEF.md
# Receive Buffer Ring Manager

This block fills a ring of equal-sized receive buffers from a stream of payload words. Each accepted word is written through a plain memory write port to the next free word position of the current buffer. A buffer is closed by whichever comes first: its last word position being written, or a programmable gathering window that starts with the buffer's first word. On closing, the block posts a one-cycle completion event and moves on to the next buffer in the ring.

A closed buffer belongs to the consumer until the consumer returns it with a release pulse that carries the buffer's index. The ring never advances its writes onto a buffer the consumer still holds. While the current buffer is held, the input is stalled and every refused offer is counted. Transport to host or accelerator memory, address translation and driver software lie outside the block. Buffer base addresses are formed as a fixed base plus the buffer index times the buffer size.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset the current buffer is index 0, every buffer is free, `in_ready` is 1, `mem_we` and `evt_valid` are 0 and `ovr_cnt` is 0.
- R2: A word accepted (`in_valid` and `in_ready` both high) at a clock edge appears on the write port in the following cycle with `mem_we`=1, unchanged data and byte address BASE_ADDR + index*BUF_BYTES + n*(DATA_W/8), where n is the word's 0-based position in its buffer.
- R3: When an accepted word takes the last word position of a buffer, the buffer closes at that edge. `evt_valid` is high for the next cycle with the buffer index, `evt_bytes`=BUF_BYTES and `evt_cause`=0 (full). Full takes precedence if the window expires at the same edge.
- R4: With `cfg_timeout`=T>0, a buffer whose first word was accepted at edge E closes at the T-th edge after E, if it is not already full. Its event carries `evt_cause`=1 (timeout) and a byte count covering every word accepted up to and including that edge.
- R5: A buffer with no words never produces an event, and `cfg_timeout`=0 disables the gathering window.
- R6: After a close, the next index in the ring becomes current (index NUM_BUFS-1 wraps to 0), and the closed buffer becomes held by the consumer.
- R7: `in_ready` is 0 exactly while the current buffer is held; words offered then are not written.
- R8: A release pulse (`rel_valid`, `rel_idx`) frees a held buffer from the next cycle on. Releasing a buffer that is already free has no effect.
- R9: `ovr_cnt` increases by one in every cycle with `in_valid`=1 and `in_ready`=0, and saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_timeout | input | TMR_W | Gathering window in cycles, 0 = off |
| in_valid | input | 1 | Payload word offered |
| in_data | input | DATA_W | Payload word |
| in_ready | output | 1 | Current buffer can take words |
| rel_valid | input | 1 | Consumer returns a buffer |
| rel_idx | input | IDX_W | Index of the returned buffer |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Byte address of the write |
| mem_wdata | output | DATA_W | Write data |
| evt_valid | output | 1 | Completion event pulse |
| evt_idx | output | IDX_W | Index of the closed buffer |
| evt_bytes | output | BYTES_W | Valid bytes in the closed buffer |
| evt_cause | output | 1 | 0 = full, 1 = window expired |
| ovr_cnt | output | OVR_W | Saturating count of refused offers |

## Verification
The bench builds the block with four buffers of 32 bytes (eight 32-bit words), an 8-bit window counter, a 4-bit overrun counter and a non-zero base address. Small buffers let a random stream fill buffers, wrap the ring and stall on held buffers many times in a few thousand cycles. The narrow overrun counter reaches saturation within one directed stall. Changing the window among off, short and long values drives full and timeout closes, including closes at the same edge.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  typedef enum logic {
    CAUSE_FULL    = 1'b0,
    CAUSE_TIMEOUT = 1'b1
  } close_cause_e;
endpackage

// File: rtl/rbm_owner_tbl.sv
// One hold bit per buffer: set on close, cleared by the consumer's release.
module rbm_owner_tbl #(
  parameter int NUM_BUFS = 4,
  parameter int IDX_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_en,
  input  logic [IDX_W-1:0]    set_idx,
  input  logic                rel_en,
  input  logic [IDX_W-1:0]    rel_idx,
  output logic [NUM_BUFS-1:0] held
);
  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        held[b] <= 1'b0;
      else if (set_en && set_idx == IDX_W'(b))
        held[b] <= 1'b1;
      else if (rel_en && rel_idx == IDX_W'(b))
        held[b] <= 1'b0;
    end
  end

  // R8: a release not colliding with a close frees the slot
  p_release_frees_r8: assert property (@(posedge clk) disable iff (rst)
    (rel_en && !(set_en && set_idx == rel_idx)) |=> !held[$past(rel_idx)]);
endmodule

// File: rtl/rbm_gather_timer.sv
// Gathering window: started by the first word of a buffer, stopped on close.
module rbm_gather_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic [TMR_W-1:0] limit,
  output logic             expire
);
  localparam logic [TMR_W-1:0] CNT_MAX = '1;

  logic             run;
  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= TMR_W'(1);
    end else if (run && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expire = run && (limit != '0) && (cnt >= limit);

  // R4: a started window counts from one on the next cycle
  p_start_count_r4: assert property (@(posedge clk) disable iff (rst)
    (start && !stop) |=> (run && cnt == TMR_W'(1)));
endmodule

// File: rtl/rbm_wr_port.sv
// Registered memory write port with buffer base address generation.
module rbm_wr_port #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 2,
  parameter int FILL_W    = 12,
  parameter int BUF_BYTES = 8192,
  parameter int BASE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  buf_idx,
  input  logic [FILL_W-1:0] word_pos,
  input  logic [DATA_W-1:0] wr_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int WORD_BYTES = DATA_W / 8;

  logic [ADDR_W-1:0] addr_nxt;

  assign addr_nxt = ADDR_W'(BASE_ADDR)
                  + ADDR_W'(buf_idx) * ADDR_W'(BUF_BYTES)
                  + ADDR_W'(word_pos) * ADDR_W'(WORD_BYTES);

  always_ff @(posedge clk) begin
    if (rst) mem_we <= 1'b0;
    else     mem_we <= wr_en;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_addr  <= addr_nxt;
      mem_wdata <= wr_data;
    end
  end
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
  import rbm_pkg::*;
#(
  parameter int NUM_BUFS  = 4,
  parameter int BUF_BYTES = 8192,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int BASE_ADDR = 0,
  parameter int TMR_W     = 16,
  parameter int OVR_W     = 16,
  localparam int IDX_W    = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
  localparam int BYTES_W  = $clog2(BUF_BYTES) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TMR_W-1:0]   cfg_timeout,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  output logic               in_ready,
  input  logic               rel_valid,
  input  logic [IDX_W-1:0]   rel_idx,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               evt_valid,
  output logic [IDX_W-1:0]   evt_idx,
  output logic [BYTES_W-1:0] evt_bytes,
  output logic               evt_cause,
  output logic [OVR_W-1:0]   ovr_cnt
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int BUF_WORDS  = BUF_BYTES / WORD_BYTES;
  localparam int FILL_W     = $clog2(BUF_WORDS) + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUFS - 1);
  localparam logic [OVR_W-1:0] OVR_MAX  = '1;

  logic [IDX_W-1:0]    wr_idx;
  logic [FILL_W-1:0]   fill;
  logic [NUM_BUFS-1:0] held;
  logic                accept, last_word, expire, close_now;
  logic [FILL_W-1:0]   fill_after;
  logic [IDX_W-1:0]    idx_next;
  close_cause_e        cause_now;

  assign in_ready   = !held[wr_idx];
  assign accept     = in_valid && in_ready;
  assign last_word  = accept && (fill == FILL_W'(BUF_WORDS - 1));
  assign close_now  = last_word || expire;
  assign fill_after = fill + FILL_W'(accept);
  assign idx_next   = (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
  assign cause_now  = last_word ? CAUSE_FULL : CAUSE_TIMEOUT;

  rbm_owner_tbl #(.NUM_BUFS(NUM_BUFS), .IDX_W(IDX_W)) u_owner (
    .clk(clk), .rst(rst),
    .set_en(close_now), .set_idx(wr_idx),
    .rel_en(rel_valid), .rel_idx(rel_idx),
    .held(held)
  );

  rbm_gather_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst(rst),
    .start(accept && fill == '0), .stop(close_now),
    .limit(cfg_timeout), .expire(expire)
  );

  rbm_wr_port #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .FILL_W(FILL_W),
    .BUF_BYTES(BUF_BYTES), .BASE_ADDR(BASE_ADDR)
  ) u_wr (
    .clk(clk), .rst(rst),
    .wr_en(accept), .buf_idx(wr_idx), .word_pos(fill), .wr_data(in_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx <= '0;
      fill   <= '0;
    end else if (close_now) begin
      wr_idx <= idx_next;
      fill   <= '0;
    end else if (accept) begin
      fill   <= fill_after;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) evt_valid <= 1'b0;
    else     evt_valid <= close_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_idx   <= '0;
      evt_bytes <= '0;
      evt_cause <= 1'b0;
    end else if (close_now) begin
      evt_idx   <= wr_idx;
      evt_bytes <= BYTES_W'(fill_after) * BYTES_W'(WORD_BYTES);
      evt_cause <= cause_now;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ovr_cnt <= '0;
    else if (in_valid && !in_ready && ovr_cnt != OVR_MAX)
      ovr_cnt <= ovr_cnt + 1'b1;
  end

  // R7: a refused offer never reaches memory
  p_refused_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> !mem_we);
  // R3: byte counts stay within one buffer and a full close reports all of it
  p_evt_bytes_range_r3: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> (evt_bytes != '0 && evt_bytes <= BYTES_W'(BUF_BYTES)));
  p_full_bytes_r3: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_cause == CAUSE_FULL) |-> evt_bytes == BYTES_W'(BUF_BYTES));
  // R6: after an event the ring points one past the closed buffer, which is held
  p_ring_advance_r6: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> (wr_idx == ((evt_idx == LAST_IDX) ? '0 : evt_idx + 1'b1)));
  // R5: an event is only produced after words were taken
  p_no_empty_close_r5: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> $past(fill != '0 || accept));
  // R9: refused offers step the counter until it saturates
  p_overrun_step_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready && ovr_cnt != OVR_MAX) |=> ovr_cnt == $past(ovr_cnt) + 1'b1);
endmodule

// File: tb/test_rx_ring_mgr.sv
module test_rx_ring_mgr;
  localparam int NB    = 4;
  localparam int BB    = 32;
  localparam int DW    = 32;
  localparam int AW    = 16;
  localparam int BASE  = 'h1000;
  localparam int TW    = 8;
  localparam int OW    = 4;
  localparam int WB    = DW / 8;
  localparam int NW    = BB / WB;
  localparam int IW    = 2;
  localparam int BYW   = $clog2(BB) + 1;
  localparam int OMAX  = (1 << OW) - 1;
  localparam int TMAX  = (1 << TW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TW-1:0] cfg_timeout = '0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready;
  logic rel_valid = 1'b0;
  logic [IW-1:0] rel_idx = '0;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic evt_valid;
  logic [IW-1:0] evt_idx;
  logic [BYW-1:0] evt_bytes;
  logic evt_cause;
  logic [OW-1:0] ovr_cnt;

  always #2.5 clk = ~clk;

  rx_ring_mgr #(
    .NUM_BUFS(NB), .BUF_BYTES(BB), .DATA_W(DW), .ADDR_W(AW),
    .BASE_ADDR(BASE), .TMR_W(TW), .OVR_W(OW)
  ) i_rx_ring_mgr (
    .clk(clk), .rst(rst), .cfg_timeout(cfg_timeout),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .rel_valid(rel_valid), .rel_idx(rel_idx),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .evt_valid(evt_valid), .evt_idx(evt_idx), .evt_bytes(evt_bytes),
    .evt_cause(evt_cause), .ovr_cnt(ovr_cnt)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference state, advanced once per clock edge
  bit m_own [NB];
  int m_idx, m_fill, m_cnt, m_ovr;
  bit m_run;
  bit e_we, e_ev, e_cause;
  int e_addr, e_idx, e_bytes;
  logic [DW-1:0] e_data;

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic int addr_of(int idx, int pos);
    return (BASE + idx * BB + pos * WB) & ((1 << AW) - 1);
  endfunction

  task automatic model_reset();
    foreach (m_own[i]) m_own[i] = 1'b0;
    m_idx = 0; m_fill = 0; m_cnt = 0; m_ovr = 0; m_run = 1'b0;
    e_we = 1'b0; e_ev = 1'b0;
  endtask

  task automatic model_step(bit v, logic [DW-1:0] d, bit rv, int ri);
    bit rdy, acc, last, tmo, cls;
    int t;
    t    = int'(cfg_timeout);
    rdy  = !m_own[m_idx];
    acc  = v && rdy;
    last = acc && (m_fill == NW - 1);
    tmo  = m_run && (t != 0) && (m_cnt >= t);
    cls  = last || tmo;
    e_we = acc;
    if (acc) begin e_addr = addr_of(m_idx, m_fill); e_data = d; end
    e_ev = cls;
    if (cls) begin
      e_idx = m_idx; e_bytes = (m_fill + int'(acc)) * WB; e_cause = !last;
    end
    if (v && !rdy && m_ovr != OMAX) m_ovr++;
    if (rv) m_own[ri] = 1'b0;
    if (cls) m_own[m_idx] = 1'b1;
    if (cls) begin m_run = 1'b0; m_cnt = 0; end
    else if (acc && m_fill == 0) begin m_run = 1'b1; m_cnt = 1; end
    else if (m_run && m_cnt != TMAX) m_cnt++;
    if (cls) begin m_fill = 0; m_idx = (m_idx + 1) % NB; end
    else if (acc) m_fill++;
  endtask

  task automatic compare_all();
    chk("R7 in_ready", in_ready, !m_own[m_idx]);
    chk("R2 mem_we", mem_we, e_we);
    if (e_we) begin
      chk("R2 mem_addr", mem_addr, e_addr);
      chk("R2 mem_wdata", mem_wdata, e_data);
    end
    chk(e_ev ? (e_cause ? "R4 evt_valid" : "R3 evt_valid") : "R5 evt_valid", evt_valid, e_ev);
    if (e_ev) begin
      chk("R6 evt_idx", evt_idx, e_idx);
      chk(e_cause ? "R4 evt_bytes" : "R3 evt_bytes", evt_bytes, e_bytes);
      chk(e_cause ? "R4 evt_cause" : "R3 evt_cause", evt_cause, e_cause);
    end
    chk("R9 ovr_cnt", ovr_cnt, m_ovr);
  endtask

  // drive one cycle of inputs, advance the reference, check after the edge
  task automatic tick(bit v, bit rv, int ri);
    logic [DW-1:0] d;
    d = $urandom;
    in_valid = v; in_data = d; rel_valid = rv; rel_idx = IW'(ri);
    model_step(v, d, rv, ri);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int ev_seen;
    void'($urandom(32'h5eed_c1a0));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    model_reset();
    // R1: reset state
    chk("R1 in_ready", in_ready, 1);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 evt_valid", evt_valid, 0);
    chk("R1 ovr_cnt", ovr_cnt, 0);

    // R3/R6: fill all four buffers with the window off, ring wraps to held 0
    cfg_timeout = '0;
    for (int i = 0; i < NB * NW; i++) tick(1, 0, 0);
    chk("R7 all held stall", in_ready, 0);
    // R9: refused offers saturate the counter
    for (int i = 0; i < OMAX + 5; i++) tick(1, 0, 0);
    chk("R9 saturated", ovr_cnt, OMAX);
    // R8: release buffer 0, input resumes
    tick(0, 1, 0);
    chk("R8 release resumes", in_ready, 1);
    for (int i = 0; i < 3; i++) tick(1, 0, 0);
    // R8: releasing the free current buffer changes nothing
    tick(0, 1, 0);
    chk("R8 free release ignored", in_ready, 1);
    tick(1, 0, 0);
    chk("R8 position kept", mem_addr, addr_of(0, 3));
    // R5: window off, partial buffer idles without an event
    ev_seen = 0;
    for (int i = 0; i < 40; i++) begin tick(0, 0, 0); ev_seen += int'(evt_valid); end
    chk("R5 no close with window off", ev_seen, 0);
    // R4: enable window, partial buffer closes by timeout
    cfg_timeout = TW'(4);
    for (int i = 0; i < 3; i++) tick(0, 0, 0);
    for (int i = 1; i < NB; i++) tick(0, 1, i);
    // R4: exact window length on a fresh buffer
    tick(1, 0, 0);
    ev_seen = 0;
    for (int i = 0; i < 4; i++) begin tick(0, 0, 0); ev_seen += int'(evt_valid); end
    chk("R4 timeout after window", ev_seen, 1);
    chk("R4 one-word bytes", evt_bytes, WB);
    // R5: empty buffer with window on stays quiet
    ev_seen = 0;
    for (int i = 0; i < 30; i++) begin tick(0, 0, 0); ev_seen += int'(evt_valid); end
    chk("R5 empty never closes", ev_seen, 0);

    // random traffic
    for (int k = 0; k < 6000; k++) begin
      if (k % 300 == 0) begin
        case ($urandom % 4)
          0: cfg_timeout = TW'(0);
          1: cfg_timeout = TW'(1);
          2: cfg_timeout = TW'(NW);
          default: cfg_timeout = TW'(3 + $urandom % 20);
        endcase
      end
      tick(($urandom % 10) < 7, ($urandom % 100) < 15, int'($urandom % NB));
    end
    in_valid = 1'b0; rel_valid = 1'b0;
    finish_run();
  end
endmodule